// File: doc/BRIEF.md
# Streaming 2x2 Max Pooling Unit

This block reduces one channel of a feature map by taking the largest of every non-overlapping 2x2 group of pixels, which halves both dimensions. Pixels come from an upstream convolution stage in raster order, one row at a time. They are signed, so negative activations compete correctly. A pooled pixel can only be formed once the second row of a pair is arriving. For that reason, every pixel of an even-numbered row is parked in a line buffer that is as deep as the image is wide. Each pixel of the following odd row is then compared against the buffered pixel in the same column.

A small FIFO sits in front of the pooling engine. It lets the producer keep pushing one pixel per clock, and it absorbs short periods when the output side is stalled. The result stream uses a valid/ready handshake. Each pooled pixel carries an end-of-row flag, and the last pooled pixel of the frame also carries an end-of-frame flag. The image width and height (both even), the pixel width and the FIFO depth are parameters.

Top module: `maxpool2x2_stream`

## Requirements
- R1: Each output pixel equals the signed maximum of four input pixels: columns 2c and 2c+1 of rows 2r and 2r+1, where r and c are the output row and column.
- R2: Outputs leave in raster order. There are IMG_W/2 outputs per output row and IMG_H/2 output rows per frame, so one output is produced for every four input pixels.
- R3: No output is produced while the first row of a pair is being received. The count of delivered outputs never exceeds one quarter of the accepted input pixels.
- R4: `out_eol` is 1 exactly on the last output of each output row, which is output column IMG_W/2-1.
- R5: `out_eof` is 1 only on the last output of the frame, and then `out_eol` is also 1. The pixel that follows starts a new frame at row 0, column 0.
- R6: While `out_valid` is 1 and `out_ready` is 0, `out_valid`, `out_pixel`, `out_eol` and `out_eof` hold their values on the next cycle.
- R7: `in_ready` falls only when the input FIFO is full. With the output stalled from reset, exactly IMG_W + 2 + FIFO_DEPTH pixels are accepted before `in_ready` stays low, and none of them is lost.
- R8: While `rst` (synchronous, active high) is held, `out_valid` is 0. After reset, `in_ready` is 1.
- R9: With `out_ready` held at 1, a producer sending one pixel per cycle never sees `in_ready` low during a frame.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input pixel valid |
| in_ready | output | 1 | Input FIFO can accept a pixel |
| in_pixel | input | PIX_W | Signed input pixel, raster order |
| out_valid | output | 1 | Pooled pixel valid |
| out_ready | input | 1 | Downstream accepts the pooled pixel |
| out_pixel | output | PIX_W | Signed pooled pixel |
| out_eol | output | 1 | Last pooled pixel of an output row |
| out_eof | output | 1 | Last pooled pixel of the frame |

## Verification
The stimulus mixes extreme values (-128, 127), windows of four equal pixels, and windows whose maximum is negative. An unsigned comparator would pick -128 over 127, and a window that ignored the buffered row would miss maxima that sit in the upper row. A stall-from-reset scenario checks the exact number of accepted pixels. A FIFO that overflowed or dropped a pixel would shift every later window, and a wrong full flag would change the count. A second frame is run with an irregular `out_ready` pattern. This exposes counters that do not restart after the end-of-frame pixel, and output registers that change while stalled.

// File: rtl/pool_pkg.sv
package pool_pkg;

  // Phase of the current input row within a row pair
  typedef enum logic {
    PH_STORE = 1'b0,  // first row of a pair: park pixels in the line buffer
    PH_POOL  = 1'b1   // second row of a pair: compare and emit
  } row_phase_e;

endpackage

// File: rtl/pool_fifo.sv
module pool_fifo #(
  parameter int DW    = 8,
  parameter int DEPTH = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_valid,
  output logic          wr_ready,
  input  logic [DW-1:0] wr_data,
  output logic          rd_valid,
  input  logic          rd_take,
  output logic [DW-1:0] rd_data
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [AW-1:0] PTR_LAST = AW'(DEPTH - 1);
  localparam logic [AW:0]   CNT_FULL = (AW + 1)'(DEPTH);

  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] wptr, rptr;
  logic [AW:0]   count;
  logic          push, pop;

  assign wr_ready = (count != CNT_FULL);
  assign rd_valid = (count != '0);
  assign rd_data  = mem[rptr];
  assign push     = wr_valid && wr_ready;
  assign pop      = rd_take && rd_valid;

  always_ff @(posedge clk) begin
    if (push) mem[wptr] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wptr  <= '0;
      rptr  <= '0;
      count <= '0;
    end else begin
      if (push) wptr <= (wptr == PTR_LAST) ? '0 : wptr + 1'b1;
      if (pop)  rptr <= (rptr == PTR_LAST) ? '0 : rptr + 1'b1;
      case ({push, pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end
endmodule

// File: rtl/pool_linebuf.sv
module pool_linebuf #(
  parameter int DW    = 8,
  parameter int DEPTH = 8
) (
  input  logic                     clk,
  input  logic                     we,
  input  logic [$clog2(DEPTH)-1:0] waddr,
  input  logic [DW-1:0]            wdata,
  input  logic [$clog2(DEPTH)-1:0] raddr,
  output logic [DW-1:0]            rdata
);
  logic [DW-1:0] mem [DEPTH];

  // Simple dual-port, registered read: maps onto block RAM
  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/pool_max2.sv
module pool_max2 #(
  parameter int W = 8
) (
  input  logic signed [W-1:0] a,
  input  logic signed [W-1:0] b,
  output logic signed [W-1:0] y
);
  assign y = (a > b) ? a : b;
endmodule

// File: rtl/pool_window.sv
module pool_window
  import pool_pkg::*;
#(
  parameter int PIX_W = 8,
  parameter int IMG_W = 8,
  parameter int IMG_H = 4
) (
  input  logic                             clk,
  input  logic                             rst,
  input  logic                             pix_valid,
  input  logic signed [PIX_W-1:0]          pix_data,
  output logic                             pix_take,
  output logic                             lb_we,
  output logic [$clog2(IMG_W)-1:0]         lb_waddr,
  output logic [PIX_W-1:0]                 lb_wdata,
  output logic [$clog2(IMG_W)-1:0]         lb_raddr,
  input  logic [PIX_W-1:0]                 lb_rdata,
  output logic                             out_valid,
  input  logic                             out_ready,
  output logic signed [PIX_W-1:0]          out_pixel,
  output logic                             out_eol,
  output logic                             out_eof
);
  localparam int CW = $clog2(IMG_W);
  localparam int RW = $clog2(IMG_H);
  localparam logic [CW-1:0] COL_LAST = CW'(IMG_W - 1);
  localparam logic [RW-1:0] ROW_LAST = RW'(IMG_H - 1);

  logic [CW-1:0] col, col_nx;
  logic [RW-1:0] row;
  logic signed [PIX_W-1:0] acc, buf_pix, max_a, max_b;
  row_phase_e phase;
  logic last_col, last_row, emit;

  assign phase    = row_phase_e'(row[0]);
  assign last_col = (col == COL_LAST);
  assign last_row = (row == ROW_LAST);
  // take a pixel whenever the output register is free or draining
  assign pix_take = pix_valid && (!out_valid || out_ready);
  assign emit     = pix_take && (phase == PH_POOL) && col[0];

  assign col_nx   = pix_take ? (last_col ? '0 : col + 1'b1) : col;

  // read address runs ahead so lb_rdata always shows the column at 'col'
  assign lb_raddr = col_nx;
  assign lb_we    = pix_take && (phase == PH_STORE);
  assign lb_waddr = col;
  assign lb_wdata = pix_data;
  assign buf_pix  = lb_rdata;

  pool_max2 #(.W(PIX_W)) u_max_col (.a(pix_data), .b(buf_pix), .y(max_a));
  pool_max2 #(.W(PIX_W)) u_max_win (.a(max_a),    .b(acc),     .y(max_b));

  always_ff @(posedge clk) begin
    if (rst) begin
      col       <= '0;
      row       <= '0;
      acc       <= '0;
      out_valid <= 1'b0;
      out_pixel <= '0;
      out_eol   <= 1'b0;
      out_eof   <= 1'b0;
    end else begin
      col <= col_nx;
      if (pix_take && last_col) row <= last_row ? '0 : row + 1'b1;
      if (pix_take && (phase == PH_POOL) && !col[0]) acc <= max_a;
      if (emit) begin
        out_valid <= 1'b1;
        out_pixel <= max_b;
        out_eol   <= last_col;
        out_eof   <= last_col && last_row;
      end else if (out_ready) begin
        out_valid <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/maxpool2x2_stream.sv
module maxpool2x2_stream #(
  parameter int PIX_W      = 8,
  parameter int IMG_W      = 8,
  parameter int IMG_H      = 4,
  parameter int FIFO_DEPTH = 4
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    in_valid,
  output logic                    in_ready,
  input  logic signed [PIX_W-1:0] in_pixel,
  output logic                    out_valid,
  input  logic                    out_ready,
  output logic signed [PIX_W-1:0] out_pixel,
  output logic                    out_eol,
  output logic                    out_eof
);
  localparam int CW = $clog2(IMG_W);

  logic             f_valid, f_take;
  logic [PIX_W-1:0] f_data;
  logic             lb_we;
  logic [CW-1:0]    lb_waddr, lb_raddr;
  logic [PIX_W-1:0] lb_wdata, lb_rdata;

  pool_fifo #(.DW(PIX_W), .DEPTH(FIFO_DEPTH)) u_fifo (
    .clk(clk), .rst(rst),
    .wr_valid(in_valid), .wr_ready(in_ready), .wr_data(in_pixel),
    .rd_valid(f_valid), .rd_take(f_take), .rd_data(f_data)
  );

  pool_linebuf #(.DW(PIX_W), .DEPTH(IMG_W)) u_linebuf (
    .clk(clk), .we(lb_we), .waddr(lb_waddr), .wdata(lb_wdata),
    .raddr(lb_raddr), .rdata(lb_rdata)
  );

  pool_window #(.PIX_W(PIX_W), .IMG_W(IMG_W), .IMG_H(IMG_H)) u_window (
    .clk(clk), .rst(rst),
    .pix_valid(f_valid), .pix_data(f_data), .pix_take(f_take),
    .lb_we(lb_we), .lb_waddr(lb_waddr), .lb_wdata(lb_wdata),
    .lb_raddr(lb_raddr), .lb_rdata(lb_rdata),
    .out_valid(out_valid), .out_ready(out_ready), .out_pixel(out_pixel),
    .out_eol(out_eol), .out_eof(out_eof)
  );
endmodule

// File: rtl/pool_checker.sv
module pool_checker #(
  parameter int PIX_W = 8,
  parameter int IMG_W = 8
) (
  input logic             clk,
  input logic             rst,
  input logic             in_valid,
  input logic             in_ready,
  input logic             out_valid,
  input logic             out_ready,
  input logic [PIX_W-1:0] out_pixel,
  input logic             out_eol,
  input logic             out_eof
);
  localparam logic [31:0] OUT_ROW_LAST = 32'(IMG_W / 2 - 1);

  logic [31:0] n_in, n_out, row_pos;

  always_ff @(posedge clk) begin
    if (rst) begin
      n_in    <= '0;
      n_out   <= '0;
      row_pos <= '0;
    end else begin
      if (in_valid && in_ready) n_in <= n_in + 1;
      if (out_valid && out_ready) begin
        n_out   <= n_out + 1;
        row_pos <= out_eol ? '0 : row_pos + 1;
      end
    end
  end

  // R3: an output needs four accepted pixels behind it
  assert_out_rate_R3: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> ((n_out + 32'd1) << 2) <= n_in);

  // R4: end-of-row flag sits on the last output column
  assert_eol_position_R4: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (out_eol == (row_pos == OUT_ROW_LAST)));

  // R5: end of frame is always also end of row
  assert_eof_with_eol_R5: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_eof) |-> out_eol);

  // R6: stalled output holds
  assert_hold_when_stalled_R6: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_pixel)
                                   && $stable(out_eol) && $stable(out_eof)));

  // R8: reset clears the output valid
  assert_reset_clears_R8: assert property (@(posedge clk)
    rst |=> !out_valid);
endmodule

bind maxpool2x2_stream pool_checker #(.PIX_W(PIX_W), .IMG_W(IMG_W)) u_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
  .out_valid(out_valid), .out_ready(out_ready), .out_pixel(out_pixel),
  .out_eol(out_eol), .out_eof(out_eof)
);

// File: tb/maxpool2x2_stream_tb.sv
module maxpool2x2_stream_tb;
  localparam int CLK_PERIOD = 10;
  localparam int PW = 8;
  localparam int W  = 8;
  localparam int H  = 4;
  localparam int FD = 4;
  localparam int NPIX = W * H;
  localparam int NOUT = (W / 2) * (H / 2);

  // stimulus frame and its expected pooled results
  localparam logic signed [PW-1:0] VEC_IN [NPIX] = '{
      8'sd3,    -8'sd5,  8'sd7,    8'sd7,    -8'sd128, -8'sd100, 8'sd0,   8'sd12,
      8'sd1,    8'sd2,   -8'sd7,   8'sd6,    -8'sd120, -8'sd128, -8'sd1,  -8'sd2,
      -8'sd1,   -8'sd2,  8'sd127,  8'sd0,    8'sd5,    8'sd5,    -8'sd60, -8'sd70,
      -8'sd3,   -8'sd4,  -8'sd128, 8'sd126,  8'sd5,    8'sd5,    -8'sd80, -8'sd50};
  localparam logic signed [PW-1:0] VEC_EXP [NOUT] = '{
      8'sd3, 8'sd7, -8'sd100, 8'sd12, -8'sd1, 8'sd127, 8'sd5, -8'sd50};

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 1'b0;
  logic signed [PW-1:0] in_pixel = '0;
  logic out_ready;
  logic in_ready, out_valid, out_eol, out_eof;
  logic signed [PW-1:0] out_pixel;

  int checks = 0;
  int failures = 0;
  int rdy_mode = 0;      // 0: always ready, 1: never, 2: irregular
  logic [7:0] lfsr = 8'hA5;
  int rx_n = 0;
  logic signed [PW-1:0] rx_pix [64];
  logic rx_eol [64];
  logic rx_eof [64];
  logic signed [PW-1:0] frame [NPIX];
  int stall_seen = 0;
  logic prev_stall = 1'b0;
  logic signed [PW-1:0] prev_pix = '0;
  logic prev_eol = 1'b0, prev_eof = 1'b0;

  maxpool2x2_stream #(.PIX_W(PW), .IMG_W(W), .IMG_H(H), .FIFO_DEPTH(FD)) u_dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_pixel(in_pixel), .out_valid(out_valid), .out_ready(out_ready),
    .out_pixel(out_pixel), .out_eol(out_eol), .out_eof(out_eof));

  always #(CLK_PERIOD / 2) clk = ~clk;

  task automatic check(input logic ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  initial out_ready = 1'b1;
  always @(posedge clk) begin
    #2;
    lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
    out_ready = (rdy_mode == 0) ? 1'b1 : (rdy_mode == 1) ? 1'b0 : lfsr[0];
  end

  // output monitor: records handshakes and checks stall hold (R6)
  always @(negedge clk) begin
    if (!rst) begin
      if (prev_stall) begin
        check(out_valid && out_pixel == prev_pix && out_eol == prev_eol
              && out_eof == prev_eof, "R6 hold", int'(out_pixel), int'(prev_pix));
      end
      if (out_valid && out_ready && rx_n < 64) begin
        rx_pix[rx_n] = out_pixel;
        rx_eol[rx_n] = out_eol;
        rx_eof[rx_n] = out_eof;
        rx_n++;
      end
      prev_stall = out_valid && !out_ready;
      prev_pix = out_pixel;
      prev_eol = out_eol;
      prev_eof = out_eof;
    end else begin
      prev_stall = 1'b0;
    end
  end

  task automatic push(input logic signed [PW-1:0] p);
    @(negedge clk);
    in_valid = 1'b1;
    in_pixel = p;
    if (!in_ready) stall_seen++;
    while (!in_ready) @(negedge clk);
    @(posedge clk);
    #1;
    in_valid = 1'b0;
  endtask

  function automatic logic signed [PW-1:0] ref_max(input int k);
    int orow = k / (W / 2);
    int ocol = k % (W / 2);
    logic signed [PW-1:0] m = frame[(2 * orow) * W + 2 * ocol];
    logic signed [PW-1:0] v [3];
    v[0] = frame[(2 * orow) * W + 2 * ocol + 1];
    v[1] = frame[(2 * orow + 1) * W + 2 * ocol];
    v[2] = frame[(2 * orow + 1) * W + 2 * ocol + 1];
    for (int j = 0; j < 3; j++) if (v[j] > m) m = v[j];
    return m;
  endfunction

  task automatic verify_frame(input string tag, input logic use_table);
    check(rx_n == NOUT, "R2 output count", rx_n, NOUT);
    for (int k = 0; k < NOUT && k < rx_n; k++) begin
      logic signed [PW-1:0] e = use_table ? VEC_EXP[k] : ref_max(k);
      check(rx_pix[k] == e, {"R1 value ", tag}, int'(rx_pix[k]), int'(e));
      check(rx_eol[k] == (k % (W / 2) == W / 2 - 1), {"R4 eol ", tag},
            int'(rx_eol[k]), int'(k % (W / 2) == W / 2 - 1));
      check(rx_eof[k] == (k == NOUT - 1), {"R5 eof ", tag},
            int'(rx_eof[k]), int'(k == NOUT - 1));
    end
  endtask

  task automatic wait_drain();
    repeat (20) @(posedge clk);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    failures++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures + 0);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(!out_valid, "R8 valid low in reset", int'(out_valid), 0);
    rst = 1'b0;
    @(negedge clk);
    check(in_ready, "R8 ready after reset", int'(in_ready), 1);

    // Frame A from the table, output always ready
    for (int i = 0; i < NPIX; i++) frame[i] = VEC_IN[i];
    rx_n = 0;
    stall_seen = 0;
    for (int i = 0; i < NPIX; i++) begin
      push(VEC_IN[i]);
      if (i == W - 1) begin
        repeat (4) @(negedge clk);
        check(rx_n == 0 && !out_valid, "R3 silent first row", rx_n, 0);
      end
    end
    wait_drain();
    check(stall_seen == 0, "R9 no input stall", stall_seen, 0);
    verify_frame("A", 1'b1);

    // Frame B: generated pixels, irregular output ready (also new frame, R5)
    for (int i = 0; i < NPIX; i++) frame[i] = PW'((i * 73 + 19) % 256 - 128);
    rx_n = 0;
    rdy_mode = 2;
    for (int i = 0; i < NPIX; i++) push(frame[i]);
    wait_drain();
    rdy_mode = 0;
    wait_drain();
    verify_frame("B", 1'b0);

    // Stall from reset: FIFO fill count (R7)
    @(negedge clk);
    rst = 1'b1;
    rdy_mode = 1;
    repeat (3) @(posedge clk);
    #1;
    rst = 1'b0;
    for (int i = 0; i < NPIX; i++) frame[i] = VEC_IN[i];
    rx_n = 0;
    begin
      int idx = 0;
      for (int c = 0; c < 40; c++) begin
        @(negedge clk);
        in_valid = 1'b1;
        in_pixel = VEC_IN[idx];
        if (in_ready) begin
          @(posedge clk);
          idx++;
        end
      end
      @(negedge clk);
      in_valid = 1'b0;
      check(idx == W + 2 + FD, "R7 accepted before full", idx, W + 2 + FD);
      check(!in_ready, "R7 ready low when full", int'(in_ready), 0);
      rdy_mode = 0;
      for (int i = idx; i < NPIX; i++) push(VEC_IN[i]);
    end
    wait_drain();
    verify_frame("stall", 1'b1);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule